// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a shared memory with two fully independent synchronous ports, a left one and a right one. Each port has its own clock. Each port can read or write any word, with per-lane byte enables. Both ports see the same storage, so a word written on one side can be read back on the other. Reads are registered. A port's output-enable pin acts without waiting for a clock, and the block raises a drive-enable that the I/O ring uses to control the pad drivers.

The two top words of the array also work as mailboxes between the two clock domains. When the left port writes the top word, the right port's interrupt output falls. When the right port later reads that word, the interrupt rises again. The word just below the top does the same job in the other direction, toward the left port. Each set request crosses the clock boundary as a toggle. A two-flop synchroniser carries it, and it is then applied in the domain of the port being interrupted. That domain also handles its own clear requests.

Top module: `mbox_dpram`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and `ce1` is 1. After a rising edge that samples the port deselected, its `q_en` is 0 for the following cycle.
- R2: A write happens on a rising edge when the port is selected and `rw` is 0. Byte lane i is bits [8i+7:8i] and is written only when `be[i]` is 1. Lanes whose enable is 0 keep their old contents.
- R3: A read happens on a rising edge when the port is selected and `rw` is 1. It puts the word at `addr` on `q`, and raises `q_en` after that same edge, one cycle after the request. A write cycle leaves `q_en` at 0 in the following cycle.
- R4: `oe_n` = 1 forces `q_en` to 0 at once, with no clock involved. Returning `oe_n` to 0 restores the pending read output at once.
- R5: A word written through either port can be read back through the other port.
- R6: A left-port write to address DEPTH-1 with at least one byte enable set drives `r_int_n` to 0. The change appears on the third rising edge of the right clock after the write edge, not earlier.
- R7: A right-port read of address DEPTH-1 with at least one byte enable set returns `r_int_n` to 1 on that same rising edge.
- R8: A mailbox write or mailbox read with all byte enables at 0 leaves the interrupt flag unchanged.
- R9: Address DEPTH-2 is the left mailbox. A right-port write to it drives `l_int_n` to 0 with the same latency as R6. A left-port read of it returns `l_int_n` to 1.
- R10: If a set request arrives in the flag's domain on the same edge as a clear request, the flag ends up set (interrupt output 0).
- R11: While a port's reset is high, its `q_en` is 0 and its interrupt output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left synchronous reset, active high |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_be | input | LANES | Left byte-lane enables |
| l_addr | input | AW | Left word address |
| l_d | input | LANES*LANE_W | Left write data |
| l_q | output | LANES*LANE_W | Left registered read data |
| l_q_en | output | 1 | Left pad drive enable (0 = outputs floating) |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right synchronous reset, active high |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_be | input | LANES | Right byte-lane enables |
| r_addr | input | AW | Right word address |
| r_d | input | LANES*LANE_W | Right write data |
| r_q | output | LANES*LANE_W | Right registered read data |
| r_q_en | output | 1 | Right pad drive enable (0 = outputs floating) |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The hardest case to reach is a set request and a clear request landing in the flag's domain on the same edge. The set only becomes visible after it has passed through the synchroniser, so both ports must be lined up on purpose. The bench drives both ports from one clock. It issues the left mailbox write, waits exactly two idle cycles, and then issues the right mailbox read, so that the read lands on the edge where the synchronised set takes effect. The interrupt must stay asserted. The mailbox accesses with all byte enables at 0 are interleaved with flags in both states, so that a clear or set that should be ignored would show up on the interrupt pin.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;

  typedef struct packed {
    logic wr;
    logic rd;
  } acc_t;

  function automatic acc_t decode_acc(input logic ce0_n, input logic ce1, input logic rw);
    acc_t a;
    a.rd = !ce0_n && ce1 && rw;
    a.wr = !ce0_n && ce1 && !rw;
    return a;
  endfunction

endpackage

// File: rtl/dpm_store.sv
`timescale 1ns/1ps
// Two-clock storage: one bank per writer plus a per-lane ownership tag pair,
// so every array has a single writing process.
module dpm_store #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                  clk_a,
  input  logic                  rst_a,
  input  logic                  we_a,
  input  logic                  re_a,
  input  logic [LANES-1:0]      be_a,
  input  logic [AW-1:0]         addr_a,
  input  logic [LANES*LW-1:0]   d_a,
  output logic [LANES*LW-1:0]   q_a,
  input  logic                  clk_b,
  input  logic                  rst_b,
  input  logic                  we_b,
  input  logic                  re_b,
  input  logic [LANES-1:0]      be_b,
  input  logic [AW-1:0]         addr_b,
  input  logic [LANES*LW-1:0]   d_b,
  output logic [LANES*LW-1:0]   q_b
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LW;

  logic [DW-1:0]    bank_a [DEPTH];
  logic [DW-1:0]    bank_b [DEPTH];
  logic [LANES-1:0] tag_a  [DEPTH];
  logic [LANES-1:0] tag_b  [DEPTH];
  logic [DW-1:0]    mix_a, mix_b;

  // Equal tags: lane last written by side A. Different: by side B.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mix_a[g*LW +: LW] = (tag_a[addr_a][g] == tag_b[addr_a][g]) ?
                               bank_a[addr_a][g*LW +: LW] : bank_b[addr_a][g*LW +: LW];
    assign mix_b[g*LW +: LW] = (tag_a[addr_b][g] == tag_b[addr_b][g]) ?
                               bank_a[addr_b][g*LW +: LW] : bank_b[addr_b][g*LW +: LW];
  end

  // Data banks: no reset, byte-lane writes, registered read.
  always_ff @(posedge clk_a) begin
    if (we_a) begin
      for (int i = 0; i < LANES; i++) begin
        if (be_a[i]) bank_a[addr_a][i*LW +: LW] <= d_a[i*LW +: LW];
      end
    end
    if (re_a) q_a <= mix_a;
  end

  always_ff @(posedge clk_b) begin
    if (we_b) begin
      for (int i = 0; i < LANES; i++) begin
        if (be_b[i]) bank_b[addr_b][i*LW +: LW] <= d_b[i*LW +: LW];
      end
    end
    if (re_b) q_b <= mix_b;
  end

  // Ownership tags.
  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      for (int w = 0; w < DEPTH; w++) tag_a[w] <= '0;
    end else if (we_a) begin
      for (int i = 0; i < LANES; i++) begin
        if (be_a[i]) tag_a[addr_a][i] <= tag_b[addr_a][i];
      end
    end
  end

  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      for (int w = 0; w < DEPTH; w++) tag_b[w] <= '0;
    end else if (we_b) begin
      for (int i = 0; i < LANES; i++) begin
        if (be_b[i]) tag_b[addr_b][i] <= ~tag_a[addr_b][i];
      end
    end
  end

endmodule

// File: rtl/dpm_port.sv
`timescale 1ns/1ps
module dpm_port
  import dpm_pkg::*;
#(
  parameter int AW       = 6,
  parameter int LANES    = 4,
  parameter int SET_ADDR = 63,
  parameter int CLR_ADDR = 62
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             rw,
  input  logic             oe_n,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  output logic             wr_en,
  output logic             rd_en,
  output logic             mb_set,
  output logic             mb_clr,
  output logic             q_en
);
  localparam logic [AW-1:0] SET_A = AW'(SET_ADDR);
  localparam logic [AW-1:0] CLR_A = AW'(CLR_ADDR);

  acc_t acc;
  logic drive_q;

  always_comb acc = decode_acc(ce0_n, ce1, rw);

  assign wr_en  = acc.wr;
  assign rd_en  = acc.rd;
  assign mb_set = acc.wr && (addr == SET_A) && (|be);
  assign mb_clr = acc.rd && (addr == CLR_A) && (|be);

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= acc.rd;
  end

  assign q_en = drive_q && !oe_n;

endmodule

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq #(
  parameter int SYNC_N = 2
) (
  input  logic set_clk,
  input  logic set_rst,
  input  logic set_req,
  input  logic flag_clk,
  input  logic flag_rst,
  input  logic clr_req,
  output logic set_hit,
  output logic irq_n
);
  logic            tgl;
  logic [SYNC_N:0] sync_q;

  always_ff @(posedge set_clk) begin
    if (set_rst)      tgl <= 1'b0;
    else if (set_req) tgl <= ~tgl;
  end

  always_ff @(posedge flag_clk) begin
    if (flag_rst) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_N-1:0], tgl};
  end

  assign set_hit = sync_q[SYNC_N] ^ sync_q[SYNC_N-1];

  always_ff @(posedge flag_clk) begin
    if (flag_rst)     irq_n <= 1'b1;
    else if (set_hit) irq_n <= 1'b0;
    else if (clr_req) irq_n <= 1'b1;
  end

endmodule

// File: rtl/mbox_dpram.sv
`timescale 1ns/1ps
module mbox_dpram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic                     clk_l,
  input  logic                     rst_l,
  input  logic                     l_ce0_n,
  input  logic                     l_ce1,
  input  logic                     l_rw,
  input  logic                     l_oe_n,
  input  logic [LANES-1:0]         l_be,
  input  logic [AW-1:0]            l_addr,
  input  logic [LANES*LANE_W-1:0]  l_d,
  output logic [LANES*LANE_W-1:0]  l_q,
  output logic                     l_q_en,
  output logic                     l_int_n,
  input  logic                     clk_r,
  input  logic                     rst_r,
  input  logic                     r_ce0_n,
  input  logic                     r_ce1,
  input  logic                     r_rw,
  input  logic                     r_oe_n,
  input  logic [LANES-1:0]         r_be,
  input  logic [AW-1:0]            r_addr,
  input  logic [LANES*LANE_W-1:0]  r_d,
  output logic [LANES*LANE_W-1:0]  r_q,
  output logic                     r_q_en,
  output logic                     r_int_n
);
  localparam int DEPTH   = 1 << AW;
  localparam int R_MBOX  = DEPTH - 1;
  localparam int L_MBOX  = DEPTH - 2;

  logic l_wr, l_rd, l_set, l_clr;
  logic r_wr, r_rd, r_set, r_clr;
  logic l_hit, r_hit;

  dpm_port #(.AW(AW), .LANES(LANES), .SET_ADDR(R_MBOX), .CLR_ADDR(L_MBOX)) u_port_l (
    .clk(clk_l), .rst(rst_l), .ce0_n(l_ce0_n), .ce1(l_ce1), .rw(l_rw), .oe_n(l_oe_n),
    .be(l_be), .addr(l_addr), .wr_en(l_wr), .rd_en(l_rd), .mb_set(l_set),
    .mb_clr(l_clr), .q_en(l_q_en)
  );

  dpm_port #(.AW(AW), .LANES(LANES), .SET_ADDR(L_MBOX), .CLR_ADDR(R_MBOX)) u_port_r (
    .clk(clk_r), .rst(rst_r), .ce0_n(r_ce0_n), .ce1(r_ce1), .rw(r_rw), .oe_n(r_oe_n),
    .be(r_be), .addr(r_addr), .wr_en(r_wr), .rd_en(r_rd), .mb_set(r_set),
    .mb_clr(r_clr), .q_en(r_q_en)
  );

  dpm_store #(.AW(AW), .LANES(LANES), .LW(LANE_W)) u_store (
    .clk_a(clk_l), .rst_a(rst_l), .we_a(l_wr), .re_a(l_rd), .be_a(l_be),
    .addr_a(l_addr), .d_a(l_d), .q_a(l_q),
    .clk_b(clk_r), .rst_b(rst_r), .we_b(r_wr), .re_b(r_rd), .be_b(r_be),
    .addr_b(r_addr), .d_b(r_d), .q_b(r_q)
  );

  // Right-port interrupt: set from the left clock, cleared on the right clock.
  mbox_irq #(.SYNC_N(SYNC_N)) u_irq_r (
    .set_clk(clk_l), .set_rst(rst_l), .set_req(l_set),
    .flag_clk(clk_r), .flag_rst(rst_r), .clr_req(r_clr),
    .set_hit(r_hit), .irq_n(r_int_n)
  );

  // Left-port interrupt: mirror image.
  mbox_irq #(.SYNC_N(SYNC_N)) u_irq_l (
    .set_clk(clk_r), .set_rst(rst_r), .set_req(r_set),
    .flag_clk(clk_l), .flag_rst(rst_l), .clr_req(l_clr),
    .set_hit(l_hit), .irq_n(l_int_n)
  );

endmodule

// File: rtl/dpm_checker.sv
`timescale 1ns/1ps
module dpm_checker (
  input logic clk_l,
  input logic rst_l,
  input logic l_ce0_n,
  input logic l_ce1,
  input logic l_rw,
  input logic l_oe_n,
  input logic l_q_en,
  input logic l_int_n,
  input logic l_hit,
  input logic l_clr,
  input logic clk_r,
  input logic rst_r,
  input logic r_ce0_n,
  input logic r_ce1,
  input logic r_oe_n,
  input logic r_q_en,
  input logic r_int_n,
  input logic r_hit,
  input logic r_clr
);

  a_r1_desel_float_l: assert property (@(posedge clk_l) disable iff (rst_l)
    (l_ce0_n || !l_ce1) |=> !l_q_en);

  a_r1_desel_float_r: assert property (@(posedge clk_r) disable iff (rst_r)
    (r_ce0_n || !r_ce1) |=> !r_q_en);

  a_r3_write_float_l: assert property (@(posedge clk_l) disable iff (rst_l)
    (!l_ce0_n && l_ce1 && !l_rw) |=> !l_q_en);

  a_r4_oe_float_l: assert property (@(posedge clk_l) disable iff (rst_l)
    l_oe_n |-> !l_q_en);

  a_r4_oe_float_r: assert property (@(posedge clk_r) disable iff (rst_r)
    r_oe_n |-> !r_q_en);

  a_r6_set_lowers_r: assert property (@(posedge clk_r) disable iff (rst_r)
    r_hit |=> !r_int_n);

  a_r6_fall_has_cause: assert property (@(posedge clk_r) disable iff (rst_r)
    $fell(r_int_n) |-> $past(r_hit));

  a_r7_clear_raises_r: assert property (@(posedge clk_r) disable iff (rst_r)
    (r_clr && !r_hit) |=> r_int_n);

  a_r9_set_lowers_l: assert property (@(posedge clk_l) disable iff (rst_l)
    l_hit |=> !l_int_n);

  a_r9_clear_raises_l: assert property (@(posedge clk_l) disable iff (rst_l)
    (l_clr && !l_hit) |=> l_int_n);

  a_r10_set_wins_r: assert property (@(posedge clk_r) disable iff (rst_r)
    (r_hit && r_clr) |=> !r_int_n);

  a_r11_reset_idle_r: assert property (@(posedge clk_r)
    rst_r |=> (r_int_n && !r_q_en));

endmodule

bind mbox_dpram dpm_checker u_chk (
  .clk_l(clk_l), .rst_l(rst_l), .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw(l_rw),
  .l_oe_n(l_oe_n), .l_q_en(l_q_en), .l_int_n(l_int_n), .l_hit(l_hit), .l_clr(l_clr),
  .clk_r(clk_r), .rst_r(rst_r), .r_ce0_n(r_ce0_n), .r_ce1(r_ce1),
  .r_oe_n(r_oe_n), .r_q_en(r_q_en), .r_int_n(r_int_n), .r_hit(r_hit), .r_clr(r_clr)
);

// File: tb/tb_mbox_dpram.sv
`timescale 1ns/1ps
module tb_mbox_dpram;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst;
  logic        ce0_n [2];
  logic        ce1   [2];
  logic        rw    [2];
  logic        oe_n  [2];
  logic [3:0]  be    [2];
  logic [5:0]  addr  [2];
  logic [31:0] d     [2];
  logic [31:0] q_l, q_r;
  logic        qen_l, qen_r, int_l, int_r;

  mbox_dpram dut (
    .clk_l(clk), .rst_l(rst), .l_ce0_n(ce0_n[0]), .l_ce1(ce1[0]), .l_rw(rw[0]),
    .l_oe_n(oe_n[0]), .l_be(be[0]), .l_addr(addr[0]), .l_d(d[0]), .l_q(q_l),
    .l_q_en(qen_l), .l_int_n(int_l),
    .clk_r(clk), .rst_r(rst), .r_ce0_n(ce0_n[1]), .r_ce1(ce1[1]), .r_rw(rw[1]),
    .r_oe_n(oe_n[1]), .r_be(be[1]), .r_addr(addr[1]), .r_d(d[1]), .r_q(q_r),
    .r_q_en(qen_r), .r_int_n(int_r)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R11";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'hA5000000 ^ (a * 32'h01030507);
  endfunction

  // ---------------- reference model ----------------
  logic [31:0] mm [64];
  logic        mdrv [2];
  logic [31:0] mdat [2];
  logic [2:0]  sh   [2];      // set-event history per flag (0 = left, 1 = right)
  logic        mint_n [2];
  bit          live = 0;

  always @(posedge clk) begin
    bit rd_p [2];
    bit wr_p [2];
    bit setev [2];
    bit clrev [2];
    live = 1;
    for (int p = 0; p < 2; p++) begin
      rd_p[p] = !ce0_n[p] && ce1[p] && rw[p];
      wr_p[p] = !ce0_n[p] && ce1[p] && !rw[p];
    end
    setev[1] = wr_p[0] && addr[0] == 6'd63 && be[0] != 0;
    clrev[1] = rd_p[1] && addr[1] == 6'd63 && be[1] != 0;
    setev[0] = wr_p[1] && addr[1] == 6'd62 && be[1] != 0;
    clrev[0] = rd_p[0] && addr[0] == 6'd62 && be[0] != 0;
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        mdrv[p] = 0; sh[p] = 0; mint_n[p] = 1;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        mdrv[p] = rd_p[p];
        if (rd_p[p]) mdat[p] = mm[addr[p]];
      end
      for (int p = 0; p < 2; p++) begin
        if (wr_p[p])
          for (int ln = 0; ln < 4; ln++)
            if (be[p][ln]) mm[addr[p]][ln*8 +: 8] = d[p][ln*8 +: 8];
      end
      for (int f = 0; f < 2; f++) begin
        if (sh[f][2])      mint_n[f] = 0;
        else if (clrev[f]) mint_n[f] = 1;
        sh[f] = {sh[f][1:0], setev[f]};
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      bit en0, en1;
      en0 = mdrv[0] && !oe_n[0];
      en1 = mdrv[1] && !oe_n[1];
      chk(qen_l === en0, cur_req, {31'd0, qen_l}, {31'd0, en0});
      chk(qen_r === en1, cur_req, {31'd0, qen_r}, {31'd0, en1});
      if (en0) chk(q_l === mdat[0], cur_req, q_l, mdat[0]);
      if (en1) chk(q_r === mdat[1], cur_req, q_r, mdat[1]);
      chk(int_l === mint_n[0], cur_req, {31'd0, int_l}, {31'd0, mint_n[0]});
      chk(int_r === mint_n[1], cur_req, {31'd0, int_r}, {31'd0, mint_n[1]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int p);
    ce0_n[p] = 1; ce1[p] = 0; rw[p] = 1; be[p] = 0;
  endtask

  task automatic acc(input int p, input bit wr, input logic [5:0] a,
                     input logic [3:0] b, input logic [31:0] dv);
    ce0_n[p] = 0; ce1[p] = 1; rw[p] = !wr; addr[p] = a; be[p] = b; d[p] = dv;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] expw;
    for (int i = 0; i < 64; i++) mm[i] = 32'h0;
    for (int p = 0; p < 2; p++) begin
      idle(p); oe_n[p] = 0; addr[p] = 0; d[p] = 0;
      mdrv[p] = 0; mdat[p] = 0; sh[p] = 0; mint_n[p] = 1;
    end
    rst = 1;
    nxt(); nxt();
    // R11: reset state
    chk(qen_l === 1'b0, "R11", {31'd0, qen_l}, 32'd0);
    chk(qen_r === 1'b0, "R11", {31'd0, qen_r}, 32'd0);
    chk(int_l === 1'b1, "R11", {31'd0, int_l}, 32'd1);
    chk(int_r === 1'b1, "R11", {31'd0, int_r}, 32'd1);
    rst = 0;
    nxt();

    // R5: fill from both sides, read back crosswise
    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 6'(i), 4'hF, pat(i));
      acc(1, 1, 6'(i + 8), 4'hF, pat(i + 8));
      nxt();
    end
    acc(0, 1, 6'd63, 4'hF, pat(63));
    acc(1, 1, 6'd62, 4'hF, pat(62));
    nxt();
    // full-word mailbox fills raised both flags; clear them
    idle(0); idle(1);
    nxt(); nxt(); nxt();
    acc(0, 0, 6'd62, 4'hF, 0);
    acc(1, 0, 6'd63, 4'hF, 0);
    nxt();
    for (int i = 0; i < 8; i++) begin
      acc(1, 0, 6'(i), 4'hF, 0);
      acc(0, 0, 6'(i + 8), 4'hF, 0);
      nxt();
    end
    idle(0); idle(1);
    nxt();
    // R3: one-cycle read latency
    cur_req = "R3";
    acc(1, 0, 6'd5, 4'hF, 0);
    chk(qen_r === 1'b0, "R3", {31'd0, qen_r}, 32'd0);
    nxt();
    idle(1);
    chk(qen_r === 1'b1, "R3", {31'd0, qen_r}, 32'd1);
    chk(q_r === pat(5), "R5", q_r, pat(5));
    nxt();

    // R2: byte-lane writes from both sides onto one word
    cur_req = "R2";
    acc(0, 1, 6'd3, 4'b0101, 32'h11223344);
    nxt();
    idle(0);
    acc(1, 1, 6'd3, 4'b1000, 32'hAABBCCDD);
    nxt();
    acc(1, 0, 6'd3, 4'hF, 0);
    nxt();
    idle(1);
    expw = {8'hAA, 8'h22, pat(3)[15:8], 8'h44};
    chk(q_r === expw, "R2", q_r, expw);
    nxt();

    // R3: write cycle keeps outputs floating
    cur_req = "R3";
    acc(0, 1, 6'd20, 4'hF, pat(20));
    nxt();
    chk(qen_l === 1'b0, "R3", {31'd0, qen_l}, 32'd0);
    idle(0);
    nxt();

    // R1: deselect via either chip enable
    cur_req = "R1";
    acc(0, 0, 6'd1, 4'hF, 0);
    nxt();
    chk(qen_l === 1'b1, "R1", {31'd0, qen_l}, 32'd1);
    ce0_n[0] = 1;
    nxt();
    chk(qen_l === 1'b0, "R1", {31'd0, qen_l}, 32'd0);
    ce0_n[0] = 0;
    nxt();
    chk(qen_l === 1'b1, "R1", {31'd0, qen_l}, 32'd1);
    ce1[0] = 0;
    nxt();
    chk(qen_l === 1'b0, "R1", {31'd0, qen_l}, 32'd0);
    idle(0);
    nxt();

    // R4: asynchronous output enable
    cur_req = "R4";
    acc(0, 0, 6'd0, 4'hF, 0);
    nxt(); nxt();
    oe_n[0] = 1;
    #0.25;
    chk(qen_l === 1'b0, "R4", {31'd0, qen_l}, 32'd0);
    oe_n[0] = 0;
    #0.25;
    chk(qen_l === 1'b1 && q_l === pat(0), "R4", q_l, pat(0));
    idle(0);
    nxt();

    // R6: left write of the right mailbox, three-edge latency
    cur_req = "R6";
    acc(0, 1, 6'd63, 4'b0001, 32'h0000_0077);
    nxt();
    idle(0);
    nxt(); nxt();
    chk(int_r === 1'b1, "R6", {31'd0, int_r}, 32'd1);
    nxt();
    chk(int_r === 1'b0, "R6", {31'd0, int_r}, 32'd0);

    // R7: right read of its mailbox clears on the same edge
    cur_req = "R7";
    acc(1, 0, 6'd63, 4'b0010, 0);
    nxt();
    idle(1);
    chk(int_r === 1'b1, "R7", {31'd0, int_r}, 32'd1);
    nxt();

    // R8: accesses with no byte enable leave the flag alone
    cur_req = "R8";
    acc(0, 1, 6'd63, 4'b0000, 32'hFFFF_FFFF);
    nxt();
    idle(0);
    repeat (4) nxt();
    chk(int_r === 1'b1, "R8", {31'd0, int_r}, 32'd1);
    acc(0, 1, 6'd63, 4'b0100, 32'h0055_0000);
    nxt();
    idle(0);
    repeat (4) nxt();
    chk(int_r === 1'b0, "R8", {31'd0, int_r}, 32'd0);
    acc(1, 0, 6'd63, 4'b0000, 0);
    nxt();
    idle(1);
    nxt();
    chk(int_r === 1'b0, "R8", {31'd0, int_r}, 32'd0);
    acc(1, 0, 6'd63, 4'b1000, 0);
    nxt();
    idle(1);
    chk(int_r === 1'b1, "R7", {31'd0, int_r}, 32'd1);
    nxt();

    // R9: left mailbox in mirror form
    cur_req = "R9";
    acc(1, 1, 6'd62, 4'b0010, 32'h0000_3300);
    nxt();
    idle(1);
    nxt(); nxt();
    chk(int_l === 1'b1, "R9", {31'd0, int_l}, 32'd1);
    nxt();
    chk(int_l === 1'b0, "R9", {31'd0, int_l}, 32'd0);
    acc(0, 0, 6'd62, 4'b0001, 0);
    nxt();
    idle(0);
    chk(int_l === 1'b1, "R9", {31'd0, int_l}, 32'd1);
    nxt();

    // R10: set and clear meet on the same right-clock edge
    cur_req = "R10";
    acc(0, 1, 6'd63, 4'b0001, 32'h0000_0099);
    nxt();
    idle(0);
    nxt(); nxt();
    acc(1, 0, 6'd63, 4'hF, 0);
    nxt();
    idle(1);
    chk(int_r === 1'b0, "R10", {31'd0, int_r}, 32'd0);
    nxt();
    acc(1, 0, 6'd63, 4'hF, 0);
    nxt();
    idle(1);
    chk(int_r === 1'b1, "R10", {31'd0, int_r}, 32'd1);
    nxt(); nxt();

    report();
  end

endmodule